// File: doc/BRIEF.md
# Real-Time Clock Register Bank with Section Bursts

This block is the register store behind a real-time clock. A serial-bus engine outside the block decodes bytes and hands them over as one-cycle strobes: transfer start, transfer stop, a device-address byte with its direction bit, a register-address byte, a write byte and a read strobe. The bank holds eight BCD timekeeping bytes, a status byte, two control bytes, eight daylight-saving bytes and twelve alarm bytes. Every other address in the 00h to 47h window is empty.

A pointer selects the register. It advances after each byte that is written or read. Bursts are confined to the section where they start, and at the section's end they wrap back to the section's first address. Writes to the timekeeping bytes need a write-enable bit in the first control byte. When a read transfer is addressed, the timekeeping bytes are copied into a holding buffer, and time reads come from that copy, so a tick in the middle of a burst cannot mix old and new fields.

Time advancement is outside the block. A tick strobe loads a full new set of time bytes.

Top module: `rtc_regbank`

## Requirements
- R1: Only device address 7'h6F opens a transfer, and o_sel goes to 1 the cycle after it. Any other device address, 7'h57 included, leaves o_sel at 0, and the address, write and read strobes that follow have no effect. A stop also clears o_sel.
- R2: After reset, the time bytes 00h–07h read 00,00,00,01,01,00,00,00. Control 0Ch reads 01h and 13h reads 00h. Daylight-saving bytes 15h–1Ch read 04,00,01,02,10,00,01,02.
- R3: A write to 00h–07h is stored only while bit 6 of 0Ch is 1. When that bit is 0, the write leaves the byte unchanged.
- R4: The pointer advances by one after each written or read byte, and stays inside its section. Time 00h–07h wraps 07h to 00h. Daylight-saving 15h–1Ch wraps 1Ch to 15h. Alarm 1Dh–28h wraps 28h to 1Dh. Status 08h stays at 08h.
- R5: The control section consists of 0Ch and 13h only. A burst steps from 0Ch to 13h and from 13h back to 0Ch.
- R6: When a read transfer is addressed, the eight time bytes are copied into a buffer, and time reads in that transfer return the copy. A tick during the transfer changes what a later transfer reads, but not what this transfer reads.
- R7: After a stop, the pointer keeps its value. A read transfer opened without an address byte continues at the address after the last byte read.
- R8: Bits with no function read 0 whatever is written. Examples: FFh written to 0Ch reads E3h, to 13h reads C0h, to 00h reads 7Fh, to 07h reads 0Fh, and 85h written to 28h reads 85h.
- R9: An unmapped address in 00h–47h reads 00h and ignores writes. The pointer steps through unmapped addresses by one, and wraps from 47h to 00h.
- R10: A tick loads all eight time bytes from the tick bus, where byte n is bits 8n+7..8n, with the field masks of R8 applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| i_start | input | 1 | Start condition seen |
| i_stop | input | 1 | Stop condition seen |
| i_dev_valid | input | 1 | Device-address byte received |
| i_dev_addr | input | 7 | Device address of that byte |
| i_dev_rd | input | 1 | Direction bit, 1 = read |
| i_addr_load | input | 1 | Register-address byte received |
| i_addr | input | 8 | Register address |
| i_wr | input | 1 | Data byte received for writing |
| i_wr_data | input | 8 | Data byte |
| i_rd_strobe | input | 1 | Current read byte consumed, advance |
| i_tick | input | 1 | Load new time values |
| i_tick_time | input | 64 | New time bytes, byte n for address n |
| o_sel | output | 1 | This bank is selected in the current transfer |
| o_rd_data | output | 8 | Byte at the pointer |

## Verification
o_rd_data is combinational from the pointer and the snapshot. The byte due for a read strobe is therefore valid during the strobe cycle itself, and the monitor compares it at the falling edge of that cycle against the head of the scoreboard queue. Writes, ticks, address loads and device selection take effect at the rising edge that ends their strobe cycle. The driver holds each strobe for exactly one cycle, so any effect is observed no earlier than the next strobe. The snapshot is taken at the edge that accepts the read device address. The tearing check pulses a tick between two read strobes of the same burst and expects the pre-tick value.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;

   typedef enum logic [2:0] {
      SEC_NONE,
      SEC_TIME,
      SEC_STAT,
      SEC_CTRL,
      SEC_DST,
      SEC_ALRM
   } sect_e;

   localparam logic [7:0] A_TIME_LO = 8'h00;
   localparam logic [7:0] A_TIME_HI = 8'h07;
   localparam logic [7:0] A_STAT    = 8'h08;
   localparam logic [7:0] A_CTRL0   = 8'h0C;
   localparam logic [7:0] A_CTRL1   = 8'h13;
   localparam logic [7:0] A_DST_LO  = 8'h15;
   localparam logic [7:0] A_DST_HI  = 8'h1C;
   localparam logic [7:0] A_ALM_LO  = 8'h1D;
   localparam logic [7:0] A_ALM_HI  = 8'h28;
   localparam logic [7:0] A_TOP     = 8'h47;
   localparam int         WREN_BIT  = 6;

   function automatic sect_e sect_of(input logic [7:0] a);
      if (a <= A_TIME_HI)                     return SEC_TIME;
      else if (a == A_STAT)                   return SEC_STAT;
      else if (a == A_CTRL0 || a == A_CTRL1)  return SEC_CTRL;
      else if (a >= A_DST_LO && a <= A_DST_HI) return SEC_DST;
      else if (a >= A_ALM_LO && a <= A_ALM_HI) return SEC_ALRM;
      else                                    return SEC_NONE;
   endfunction

   function automatic logic [7:0] next_ptr(input logic [7:0] a);
      logic [7:0] n;
      case (sect_of(a))
         SEC_TIME: n = (a == A_TIME_HI) ? A_TIME_LO : a + 8'd1;
         SEC_STAT: n = A_STAT;
         SEC_CTRL: n = (a == A_CTRL0) ? A_CTRL1 : A_CTRL0;
         SEC_DST:  n = (a == A_DST_HI) ? A_DST_LO : a + 8'd1;
         SEC_ALRM: n = (a == A_ALM_HI) ? A_ALM_LO : a + 8'd1;
         default:  n = (a >= A_TOP) ? 8'h00 : a + 8'd1;
      endcase
      return n;
   endfunction

   // Alarm bank entries repeat every six bytes (seconds..weekday).
   function automatic logic [7:0] alarm_mask(input int unsigned k);
      case (k)
         0, 1:    return 8'hFF;
         2, 3:    return 8'hBF;
         4:       return 8'h9F;
         default: return 8'h87;
      endcase
   endfunction

   function automatic logic [7:0] wmask(input logic [7:0] a);
      case (a)
         8'h00, 8'h01: return 8'h7F;
         8'h02:        return 8'hBF;
         8'h03:        return 8'h3F;
         8'h04:        return 8'h1F;
         8'h05:        return 8'hFF;
         8'h06:        return 8'h07;
         8'h07:        return 8'h0F;
         8'h08:        return 8'hB9;
         8'h0C:        return 8'hE3;
         8'h13:        return 8'hC0;
         8'h15:        return 8'h9F;
         8'h16, 8'h1A: return 8'h7F;
         8'h17, 8'h1B: return 8'h3F;
         8'h18, 8'h1C: return 8'hBF;
         8'h19:        return 8'h1F;
         default: begin
            if (sect_of(a) == SEC_ALRM)
               return alarm_mask(32'((a - A_ALM_LO) % 8'd6));
            return 8'h00;
         end
      endcase
   endfunction

   function automatic logic [7:0] rst_val(input logic [7:0] a);
      case (a)
         8'h03, 8'h04, 8'h08, 8'h0C: return 8'h01;
         8'h15:                      return 8'h04;
         8'h17, 8'h1B:               return 8'h01;
         8'h18, 8'h1C:               return 8'h02;
         8'h19:                      return 8'h10;
         8'h20, 8'h21, 8'h26, 8'h27: return 8'h01;
         default:                    return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bus_ctl.sv
module rtc_bus_ctl #(
   parameter int          DEV_W    = 7,
   parameter logic [6:0]  DEV_ADDR = 7'h6F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             dev_valid_i,
   input  logic [DEV_W-1:0] dev_addr_i,
   input  logic             dev_rd_i,
   output logic             sel_o,
   output logic             rd_mode_o,
   output logic             snap_req_o
);
   logic hit;
   assign hit        = (dev_addr_i == DEV_ADDR[DEV_W-1:0]);
   assign snap_req_o = dev_valid_i & hit & dev_rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o     <= 1'b0;
         rd_mode_o <= 1'b0;
      end else if (start_i || stop_i) begin
         sel_o     <= 1'b0;
      end else if (dev_valid_i) begin
         sel_o     <= hit;
         rd_mode_o <= dev_rd_i;
      end
   end

   AST_STOP_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> !sel_o); // R1
   AST_MISS_NOT_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_valid_i && !hit && !start_i && !stop_i) |=> !sel_o); // R1
endmodule

// File: rtl/rtc_ptr.sv
module rtc_ptr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] ptr_o
);
   import rtc_regbank_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= addr_i;
      else if (step_i) ptr_o <= next_ptr(ptr_o);
   end

   AST_STAY_IN_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && sect_of(ptr_o) != SEC_NONE)
      |=> sect_of(ptr_o) == $past(sect_of(ptr_o))); // R4
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(ptr_o)); // R7
endmodule

// File: rtl/rtc_time_bank.sv
module rtc_time_bank #(
   parameter int DATA_W     = 8,
   parameter int TIME_BYTES = 8,
   parameter bit SNAP_EN    = 1'b1,
   localparam int IDX_W     = $clog2(TIME_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_i,
   input  logic                         wr_ok_i,
   input  logic [IDX_W-1:0]             idx_i,
   input  logic [DATA_W-1:0]            wdata_i,
   input  logic                         tick_i,
   input  logic [TIME_BYTES*DATA_W-1:0] tick_time_i,
   input  logic                         snap_req_i,
   output logic [DATA_W-1:0]            rdata_o
);
   import rtc_regbank_pkg::*;

   logic [TIME_BYTES*DATA_W-1:0] live_q;
   logic [TIME_BYTES*DATA_W-1:0] view;

   for (genvar g = 0; g < TIME_BYTES; g++) begin : g_byte
      localparam logic [7:0] AD = 8'(g);
      localparam logic [DATA_W-1:0] MSK = DATA_W'(wmask(AD));
      localparam logic [DATA_W-1:0] RST = DATA_W'(rst_val(AD));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            live_q[g*DATA_W +: DATA_W] <= RST;
         else if (wr_i && wr_ok_i && idx_i == IDX_W'(g))
            live_q[g*DATA_W +: DATA_W] <= wdata_i & MSK;
         else if (tick_i)
            live_q[g*DATA_W +: DATA_W] <= tick_time_i[g*DATA_W +: DATA_W] & MSK;
      end
   end

   if (SNAP_EN) begin : g_snap
      logic [TIME_BYTES*DATA_W-1:0] snap_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          snap_q <= '0;
         else if (snap_req_i) snap_q <= live_q;
      end
      assign view = snap_q;
      AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
         !snap_req_i |=> $stable(snap_q)); // R6
   end else begin : g_live
      assign view = live_q;
   end

   assign rdata_o = view[idx_i*DATA_W +: DATA_W];

   AST_TIME_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !(wr_i && wr_ok_i)) |=> $stable(live_q)); // R3
endmodule

// File: rtl/rtc_cfg_bank.sv
module rtc_cfg_bank #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter int N_ADDR = 72
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              time_wren_o
);
   import rtc_regbank_pkg::*;

   logic [DATA_W-1:0] cfg_q [N_ADDR];

   for (genvar g = 0; g < N_ADDR; g++) begin : g_reg
      localparam logic [7:0] AD = 8'(g);
      if (sect_of(AD) != SEC_NONE && sect_of(AD) != SEC_TIME) begin : g_ff
         localparam logic [DATA_W-1:0] MSK = DATA_W'(wmask(AD));
         localparam logic [DATA_W-1:0] RST = DATA_W'(rst_val(AD));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[g] <= RST;
            else if (wr_i && addr_i == ADDR_W'(g))
               cfg_q[g] <= wdata_i & MSK;
         end
      end else begin : g_hole
         assign cfg_q[g] = '0;
      end
   end

   assign rdata_o     = (addr_i < ADDR_W'(N_ADDR)) ? cfg_q[addr_i[6:0]] : '0;
   assign time_wren_o = cfg_q[A_CTRL0][WREN_BIT];

   AST_CTRL1_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == ADDR_W'(A_CTRL1)) |=> cfg_q[A_CTRL1][5:0] == '0); // R8
   AST_HOLE_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sect_of(addr_i) == SEC_NONE) |=> $stable(cfg_q[A_CTRL0])); // R9
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
   parameter int         DATA_W     = 8,
   parameter int         ADDR_W     = 8,
   parameter int         DEV_W      = 7,
   parameter int         TIME_BYTES = 8,
   parameter logic [6:0] DEV_ADDR   = 7'h6F,
   parameter bit         SNAP_EN    = 1'b1,
   localparam int        N_ADDR     = 72,
   localparam int        TIME_IDX_W = $clog2(TIME_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         i_start,
   input  logic                         i_stop,
   input  logic                         i_dev_valid,
   input  logic [DEV_W-1:0]             i_dev_addr,
   input  logic                         i_dev_rd,
   input  logic                         i_addr_load,
   input  logic [ADDR_W-1:0]            i_addr,
   input  logic                         i_wr,
   input  logic [DATA_W-1:0]            i_wr_data,
   input  logic                         i_rd_strobe,
   input  logic                         i_tick,
   input  logic [TIME_BYTES*DATA_W-1:0] i_tick_time,
   output logic                         o_sel,
   output logic [DATA_W-1:0]            o_rd_data
);
   import rtc_regbank_pkg::*;

   if (DATA_W != 8)     begin : g_bad_dw  $error("BCD layout needs 8-bit bytes"); end
   if (ADDR_W != 8)     begin : g_bad_aw  $error("register map needs 8-bit addresses"); end
   if (TIME_BYTES != 8) begin : g_bad_tb  $error("time section is eight bytes"); end
   if (DEV_W != 7)      begin : g_bad_dev $error("device address is seven bits"); end

   logic              rd_mode, snap_req, wr_go, rd_go, load_go, time_wren;
   logic [ADDR_W-1:0] ptr;
   logic [DATA_W-1:0] time_rd, cfg_rd;
   sect_e             cur_sect;

   rtc_bus_ctl #(.DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR)) u_ctl (
      .clk(clk), .rst_n(rst_n), .start_i(i_start), .stop_i(i_stop),
      .dev_valid_i(i_dev_valid), .dev_addr_i(i_dev_addr), .dev_rd_i(i_dev_rd),
      .sel_o(o_sel), .rd_mode_o(rd_mode), .snap_req_o(snap_req));

   assign wr_go   = o_sel & ~rd_mode & i_wr;
   assign load_go = o_sel & ~rd_mode & i_addr_load;
   assign rd_go   = o_sel &  rd_mode & i_rd_strobe;

   rtc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(load_go), .addr_i(i_addr),
      .step_i(wr_go | rd_go), .ptr_o(ptr));

   assign cur_sect = sect_of(ptr);

   rtc_time_bank #(.DATA_W(DATA_W), .TIME_BYTES(TIME_BYTES), .SNAP_EN(SNAP_EN)) u_time (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_go && cur_sect == SEC_TIME), .wr_ok_i(time_wren),
      .idx_i(ptr[TIME_IDX_W-1:0]), .wdata_i(i_wr_data),
      .tick_i(i_tick), .tick_time_i(i_tick_time),
      .snap_req_i(snap_req), .rdata_o(time_rd));

   rtc_cfg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ADDR(N_ADDR)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_go && cur_sect != SEC_TIME), .addr_i(ptr), .wdata_i(i_wr_data),
      .rdata_o(cfg_rd), .time_wren_o(time_wren));

   always_comb begin
      case (cur_sect)
         SEC_TIME: o_rd_data = time_rd;
         SEC_NONE: o_rd_data = '0;
         default:  o_rd_data = cfg_rd;
      endcase
   end

   AST_LOCKED_TIME_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && cur_sect == SEC_TIME && !time_wren && !i_tick)
      |=> $stable(u_time.live_q)); // R3
endmodule

// File: tb/test_rtc_regbank.sv
`timescale 1ns/1ps
module test_rtc_regbank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        i_start = 0, i_stop = 0, i_dev_valid = 0, i_dev_rd = 0;
   logic [6:0]  i_dev_addr = '0;
   logic        i_addr_load = 0, i_wr = 0, i_rd_strobe = 0, i_tick = 0;
   logic [7:0]  i_addr = '0, i_wr_data = '0;
   logic [63:0] i_tick_time = '0;
   logic        o_sel;
   logic [7:0]  o_rd_data;

   int n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #4 clk = ~clk;

   rtc_regbank i_rtc_regbank (
      .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_stop(i_stop),
      .i_dev_valid(i_dev_valid), .i_dev_addr(i_dev_addr), .i_dev_rd(i_dev_rd),
      .i_addr_load(i_addr_load), .i_addr(i_addr), .i_wr(i_wr), .i_wr_data(i_wr_data),
      .i_rd_strobe(i_rd_strobe), .i_tick(i_tick), .i_tick_time(i_tick_time),
      .o_sel(o_sel), .o_rd_data(o_rd_data));

   // Monitor: read data is due in the strobe cycle itself.
   always @(negedge clk) begin
      if (rst_n && i_rd_strobe) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read: actual %02h expected none", o_rd_data);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (o_rd_data !== e) begin
               n_fail++;
               $display("FAIL %s: actual %02h expected %02h", t, o_rd_data, e);
            end
         end
      end
   end

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", t, act, exp);
      end
   endtask

   task automatic step1();
      @(posedge clk); #1;
   endtask

   task automatic dev(input logic [6:0] a, input logic rd);
      i_start = 1; step1(); i_start = 0;
      i_dev_valid = 1; i_dev_addr = a; i_dev_rd = rd; step1(); i_dev_valid = 0;
   endtask

   task automatic stop();
      i_stop = 1; step1(); i_stop = 0;
   endtask

   task automatic seta(input logic [7:0] a);
      i_addr_load = 1; i_addr = a; step1(); i_addr_load = 0;
   endtask

   task automatic wr(input logic [7:0] d);
      i_wr = 1; i_wr_data = d; step1(); i_wr = 0;
   endtask

   task automatic rd(input logic [7:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      i_rd_strobe = 1; step1(); i_rd_strobe = 0;
   endtask

   task automatic open_rd(input logic [7:0] a);
      dev(7'h6F, 0); seta(a); dev(7'h6F, 1);
   endtask

   task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
      dev(7'h6F, 0); seta(a); wr(d); stop();
   endtask

   task automatic tick(input logic [63:0] t);
      i_tick = 1; i_tick_time = t; step1(); i_tick = 0;
   endtask

   task automatic finish_run();
      if (exp_q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      step1();
      chk({7'd0, o_sel}, 8'h00, "R1 idle after reset");

      // R2 reset values plus time wrap (R4)
      open_rd(8'h00);
      chk({7'd0, o_sel}, 8'h01, "R1 selected by 6F");
      rd(8'h00, "R2 sec"); rd(8'h00, "R2 min"); rd(8'h00, "R2 hour");
      rd(8'h01, "R2 date"); rd(8'h01, "R2 month"); rd(8'h00, "R2 year");
      rd(8'h00, "R2 wday"); rd(8'h00, "R2 sub");
      rd(8'h00, "R4 time wrap to 00");
      stop();
      chk({7'd0, o_sel}, 8'h00, "R1 stop deselects");
      open_rd(8'h0C); rd(8'h01, "R2 ctrl0"); rd(8'h00, "R2 ctrl1"); stop();
      open_rd(8'h15);
      rd(8'h04, "R2 dst15"); rd(8'h00, "R2 dst16"); rd(8'h01, "R2 dst17"); rd(8'h02, "R2 dst18");
      rd(8'h10, "R2 dst19"); rd(8'h00, "R2 dst1A"); rd(8'h01, "R2 dst1B"); rd(8'h02, "R2 dst1C");
      rd(8'h04, "R4 dst wrap to 15");
      stop();

      // R3 write protection
      wr_at(8'h00, 8'h45);
      open_rd(8'h00); rd(8'h00, "R3 locked write ignored"); stop();
      wr_at(8'h0C, 8'h41);
      wr_at(8'h00, 8'h45);
      open_rd(8'h00); rd(8'h45, "R3 unlocked write stored"); stop();

      // R5 + R8 control pair and masks
      dev(7'h6F, 0); seta(8'h0C); wr(8'hFF); wr(8'hFF); stop();
      open_rd(8'h0C);
      rd(8'hE3, "R8 ctrl0 mask"); rd(8'hC0, "R8 ctrl1 mask"); rd(8'hE3, "R5 ctrl wrap to 0C");
      stop();

      // R4/R8 time burst wraps 07 -> 00
      dev(7'h6F, 0); seta(8'h07); wr(8'hFF); wr(8'hFF); stop();
      open_rd(8'h07); rd(8'h0F, "R8 sub-second mask"); rd(8'h7F, "R8 seconds mask after wrap R4"); stop();

      // R4 alarm wrap 28 -> 1D
      dev(7'h6F, 0); seta(8'h28); wr(8'h85); wr(8'h55); stop();
      open_rd(8'h28); rd(8'h85, "R8 alarm weekday"); rd(8'h55, "R4 alarm wrap to 1D"); stop();

      // R4 status stays put
      open_rd(8'h08); rd(8'h01, "R4 status"); rd(8'h01, "R4 status stays"); stop();

      // R9 unmapped
      dev(7'h6F, 0); seta(8'h09); wr(8'hFF); wr(8'hFF); stop();
      open_rd(8'h09); rd(8'h00, "R9 hole 09 reads zero"); rd(8'h00, "R9 hole 0A reads zero");
      rd(8'h00, "R9 hole 0B"); rd(8'hE3, "R9 hole steps into 0C"); stop();
      open_rd(8'h47); rd(8'h00, "R9 hole 47"); rd(8'h7F, "R9 47 wraps to 00"); stop();

      // R1 foreign device ignored
      dev(7'h57, 0);
      chk({7'd0, o_sel}, 8'h00, "R1 57 not selected");
      seta(8'h15); wr(8'h0A); stop();
      open_rd(8'h15); rd(8'h04, "R1 foreign write ignored"); stop();

      // R10 tick load
      tick(64'h03_02_24_12_31_23_59_58);
      open_rd(8'h00);
      rd(8'h58, "R10 sec"); rd(8'h59, "R10 min"); rd(8'h23, "R10 hour"); rd(8'h31, "R10 date");
      rd(8'h12, "R10 month"); rd(8'h24, "R10 year"); rd(8'h02, "R10 wday"); rd(8'h03, "R10 sub");
      stop();
      tick(64'hFF_FF_99_FF_FF_FF_FF_FF);
      open_rd(8'h06); rd(8'h07, "R10 wday masked"); rd(8'h0F, "R10 sub masked"); stop();

      // R6 snapshot across tick
      tick(64'h03_02_24_12_31_23_59_58);
      open_rd(8'h00);
      rd(8'h58, "R6 first byte");
      tick(64'h03_02_24_12_31_23_00_10);
      rd(8'h59, "R6 snapshot kept");
      stop();
      open_rd(8'h00); rd(8'h10, "R6 new transfer sees tick"); rd(8'h00, "R6 new minute"); stop();

      // R7 current-address read continues
      open_rd(8'h17); rd(8'h01, "R7 dst17"); stop();
      dev(7'h6F, 1); rd(8'h02, "R7 continues at 18"); stop();

      step1();
      finish_run();
   end
endmodule